// File: doc/BRIEF.md
# Sticky Diagnostic Status Register

This block gathers error events from a sensor's monitoring logic into one 16-bit status word that a host reads over a register interface. Each monitor drives a one-cycle event pulse. When the monitor is enabled, the pulse sets a sticky error bit. That bit then holds until the host reads the word, and the read clears it. A changed-since-last-read flag in the top bit tells the host whether any error bit has newly latched since its previous read. The word also holds a 2-bit device address field. This field takes its value from two strap pins at reset, and the host may overwrite it.

One monitor is built into the block: a window comparator on the raw X/Y samples. The remaining events come from outside. While auto-calibration runs, the configuration-checksum bit is held inactive, because calibration rewrites the registers that the checksum covers. The reset-indication bit comes up set and stays set until the first read, so the host can detect any reset.

Top module: `diag_status_reg`

## Requirements
- R1: Reset is synchronous and active-high. After reset, the word is 0x8001 when both straps are low: bit 15 (changed flag) and bit 0 (reset indication) are 1, and every other error bit is 0.
- R2: Error bits map as follows. evt_i[7:0] drive word bits 7:0 and evt_i[11:8] drive word bits 12:9. An enabled event pulse sets its bit on the next clock edge, and the bit then holds with no further events.
- R3: stat_o shows the pre-clear value in the cycle where rd_i is high. From the next cycle, every error bit that had no new event during that read cycle reads 0.
- R4: An enabled event that arrives in the same cycle as a read leaves its bit set after the read.
- R5: When mon_en_i[k] is 0, an event on evt_i[k] has no effect on the word.
- R6: Bit 15 becomes 1 whenever an error bit goes from clear (after any same-cycle read) to set. A read with no such new latch returns bit 15 to 0. Writes to the address field do not touch bit 15.
- R7: Out of reset, bit 13 equals strap_lo_i and bit 14 equals strap_hi_i. A write loads bits 14:13 from wr_data_i[14:13].
- R8: A write changes no bit other than 14:13, and bit 8 always reads 0.
- R9: When raw_vld_i is high and raw_x_i or raw_y_i (signed 16-bit) is above +23230 or below -23230, this counts as an event for bit 6. A value of exactly ±23230 does not.
- R10: While autocal_i is 1, bit 3 reads 0 from the next cycle, and events for bit 3 are ignored.
- R11: Only a read clears the reset-indication bit 0. Without a read, it stays 1 for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_lo_i | input | 1 | Strap for address bit 13, sampled during reset |
| strap_hi_i | input | 1 | Strap for address bit 14, sampled during reset |
| evt_i | input | 12 | Monitor event pulses, one per error bit |
| mon_en_i | input | 12 | Per-monitor enable |
| autocal_i | input | 1 | Auto-calibration active; holds bit 3 at 0 |
| raw_vld_i | input | 1 | Raw X/Y sample valid |
| raw_x_i | input | 16 | Raw X sample, signed |
| raw_y_i | input | 16 | Raw Y sample, signed |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| wr_data_i | input | 16 | Write data; only bits 14:13 are used |
| stat_o | output | 16 | Status word |

## Verification
Every state bit in this block appears directly in stat_o, so a wrong latch, clear or flag update is visible in the cycle after the edge that caused it. The bench compares the whole word in every cycle, which means a fault is reported within one clock. A lost same-cycle event, or a mask leak, turns up as a single wrong bit on the cycle after the read or event. A wrong strap mapping is already visible in the first word after reset.

// File: rtl/diag_stat_pkg.sv
package diag_stat_pkg;

    localparam int WORD_W   = 16;
    localparam int NUM_ERR  = 12;
    localparam int SN_W     = 2;
    localparam int RAW_W    = 16;
    localparam int XY_LIMIT = 23230;

    localparam int ERR_RST  = 0;
    localparam int ERR_CRC  = 3;
    localparam int ERR_XY   = 6;
    localparam int LO_W     = 8;
    localparam int HI_W     = NUM_ERR - LO_W;

    typedef struct packed {
        logic              chg;
        logic [SN_W-1:0]   sn;
        logic [HI_W-1:0]   err_hi;
        logic              resv;
        logic [LO_W-1:0]   err_lo;
    } stat_word_t;

    function automatic stat_word_t pack_word(input logic chg,
                                             input logic [SN_W-1:0] sn,
                                             input logic [NUM_ERR-1:0] err);
        stat_word_t w;
        w.chg    = chg;
        w.sn     = sn;
        w.err_hi = err[NUM_ERR-1:LO_W];
        w.resv   = 1'b0;
        w.err_lo = err[LO_W-1:0];
        return w;
    endfunction

endpackage

// File: rtl/diag_xy_window.sv
module diag_xy_window
    import diag_stat_pkg::*;
#(
    parameter int W     = RAW_W,
    parameter int LIMIT = XY_LIMIT
) (
    input  logic                vld_i,
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    output logic                hit_o
);
    localparam logic signed [W-1:0] POS_LIM = LIMIT;
    localparam logic signed [W-1:0] NEG_LIM = -LIMIT;

    logic x_out, y_out;

    always_comb begin
        x_out = (x_i > POS_LIM) || (x_i < NEG_LIM);
        y_out = (y_i > POS_LIM) || (y_i < NEG_LIM);
        hit_o = vld_i && (x_out || y_out);
    end
endmodule

// File: rtl/diag_sticky_cell.sv
module diag_sticky_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic force_off_i,
    output logic q_o,
    output logic rise_o
);
    logic base;

    always_comb begin
        base   = clr_i ? 1'b0 : q_o;
        rise_o = set_i && !force_off_i && !base;
    end

    always_ff @(posedge clk) begin
        if (rst)              q_o <= RST_VAL;
        else if (force_off_i) q_o <= 1'b0;
        else                  q_o <= base | set_i;
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (q_o && !clr_i && !force_off_i) |=> q_o);
    p_catch_r4: assert property (@(posedge clk) disable iff (rst)
        (set_i && !force_off_i) |=> q_o);
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o);
    p_force_r10: assert property (@(posedge clk) disable iff (rst)
        force_off_i |=> !q_o);
endmodule

// File: rtl/diag_slave_field.sv
module diag_slave_field
    import diag_stat_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [SN_W-1:0] strap_i,
    input  logic            wr_i,
    input  logic [SN_W-1:0] wr_val_i,
    output logic [SN_W-1:0] sn_o
);
    always_ff @(posedge clk) begin
        if (rst)       sn_o <= strap_i;
        else if (wr_i) sn_o <= wr_val_i;
    end

    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (sn_o == $past(wr_val_i)));
    p_keep_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(sn_o));
endmodule

// File: rtl/diag_status_reg.sv
module diag_status_reg
    import diag_stat_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    strap_lo_i,
    input  logic                    strap_hi_i,
    input  logic [NUM_ERR-1:0]      evt_i,
    input  logic [NUM_ERR-1:0]      mon_en_i,
    input  logic                    autocal_i,
    input  logic                    raw_vld_i,
    input  logic signed [RAW_W-1:0] raw_x_i,
    input  logic signed [RAW_W-1:0] raw_y_i,
    input  logic                    rd_i,
    input  logic                    wr_i,
    input  logic [WORD_W-1:0]       wr_data_i,
    output logic [WORD_W-1:0]       stat_o
);
    localparam int SN_LSB = LO_W + 1 + HI_W;

    logic               xy_hit;
    logic [NUM_ERR-1:0] raw_evt;
    logic [NUM_ERR-1:0] set_v;
    logic [NUM_ERR-1:0] err_q;
    logic [NUM_ERR-1:0] rise_v;
    logic [SN_W-1:0]    sn_q;
    logic               chg_q;
    stat_word_t         word;
    logic               unused_wr;

    assign unused_wr = ^{wr_data_i[WORD_W-1], wr_data_i[SN_LSB-1:0]};

    diag_xy_window #(.W(RAW_W), .LIMIT(XY_LIMIT)) u_xy (
        .vld_i (raw_vld_i),
        .x_i   (raw_x_i),
        .y_i   (raw_y_i),
        .hit_o (xy_hit)
    );

    always_comb begin
        raw_evt         = evt_i;
        raw_evt[ERR_XY] = evt_i[ERR_XY] | xy_hit;
        set_v           = raw_evt & mon_en_i;
    end

    for (genvar i = 0; i < NUM_ERR; i++) begin : g_bit
        localparam logic RV = (i == ERR_RST);
        logic force_off;
        if (i == ERR_CRC) begin : g_crc
            assign force_off = autocal_i;
        end else begin : g_plain
            assign force_off = 1'b0;
        end
        diag_sticky_cell #(.RST_VAL(RV)) u_cell (
            .clk         (clk),
            .rst         (rst),
            .set_i       (set_v[i]),
            .clr_i       (rd_i),
            .force_off_i (force_off),
            .q_o         (err_q[i]),
            .rise_o      (rise_v[i])
        );
    end

    diag_slave_field u_sn (
        .clk      (clk),
        .rst      (rst),
        .strap_i  ({strap_hi_i, strap_lo_i}),
        .wr_i     (wr_i),
        .wr_val_i (wr_data_i[SN_LSB +: SN_W]),
        .sn_o     (sn_q)
    );

    always_ff @(posedge clk) begin
        if (rst) chg_q <= 1'b1;
        else     chg_q <= (rd_i ? 1'b0 : chg_q) | (|rise_v);
    end

    always_comb begin
        word   = pack_word(chg_q, sn_q, err_q);
        stat_o = word;
    end

    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
        (|rise_v) |=> stat_o[WORD_W-1]);
    p_flag_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !(|rise_v)) |=> !stat_o[WORD_W-1]);
    p_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_i && (set_v == '0)) |=> (err_q == '0));
endmodule

// File: tb/sim_diag_status_reg.sv
module sim_diag_status_reg;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               strap_lo = 1'b0, strap_hi = 1'b0;
    logic [11:0]        evt = '0, en = '1;
    logic               acal = 1'b0, vld = 1'b0, rd = 1'b0, wr = 1'b0;
    logic signed [15:0] xs = '0, ys = '0;
    logic [15:0]        wdata = '0;
    logic [15:0]        stat;
    int                 checks = 0, errors = 0, cycles = 0;
    logic [15:0]        exp_w;

    always #5 clk = ~clk;

    diag_status_reg u0 (
        .clk(clk), .rst(rst), .strap_lo_i(strap_lo), .strap_hi_i(strap_hi),
        .evt_i(evt), .mon_en_i(en), .autocal_i(acal), .raw_vld_i(vld),
        .raw_x_i(xs), .raw_y_i(ys), .rd_i(rd), .wr_i(wr),
        .wr_data_i(wdata), .stat_o(stat)
    );

    function automatic logic [15:0] model(input logic [15:0] cur,
            input logic [11:0] e, input logic [11:0] m, input logic r,
            input logic w, input logic [15:0] wd, input logic v,
            input logic signed [15:0] x, input logic signed [15:0] y,
            input logic ac);
        logic [11:0] err, nw, base, nxt, rise;
        logic        flag;
        logic [1:0]  sn;
        err = {cur[12:9], cur[7:0]};
        nw  = e;
        if (v && (x > 23230 || x < -23230 || y > 23230 || y < -23230)) nw[6] = 1'b1;
        nw = nw & m;
        if (ac) nw[3] = 1'b0;
        base = r ? 12'h000 : err;
        nxt  = base | nw;
        if (ac) nxt[3] = 1'b0;
        rise = nw & ~base;
        flag = (r ? 1'b0 : cur[15]) | (|rise);
        sn   = w ? wd[14:13] : cur[14:13];
        return {flag, sn, nxt[11:8], 1'b0, nxt[7:0]};
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: stat=%h expected=%h at cycle %0d", req, got, exp, cycles);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input logic [11:0] e, input logic r, input logic w,
                         input logic [15:0] wd, input logic v,
                         input logic signed [15:0] x, input logic signed [15:0] y);
        evt = e; rd = r; wr = w; wdata = wd; vld = v; xs = x; ys = y;
        tick();
        evt = '0; rd = 1'b0; wr = 1'b0; vld = 1'b0;
    endtask

    always @(posedge clk) cycles++;

    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: run hung");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1 R7: reset with strap_hi high
        strap_hi = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1/R7 strap reset", stat, 16'hC001);
        repeat (5) tick();
        check("R11 reset bit held", stat, 16'hC001);
        // R3: read shows pre-clear value, then clears
        rd = 1'b1;
        #1 check("R3 pre-clear value", stat, 16'hC001);
        tick(); rd = 1'b0;
        check("R3/R6 after read", stat, 16'h4000);
        // R2 latch and hold
        pulse(12'h002, 0, 0, 16'h0, 0, 0, 0);
        check("R2/R6 latch", stat, 16'hC002);
        repeat (4) tick();
        check("R2 hold", stat, 16'hC002);
        // R4 event during read
        pulse(12'h002, 1, 0, 16'h0, 0, 0, 0);
        check("R4 same-cycle event", stat, 16'hC002);
        pulse(12'h000, 1, 0, 16'h0, 0, 0, 0);
        check("R3 plain read", stat, 16'h4000);
        // R5 masking
        en = 12'hFDF;
        pulse(12'h020, 0, 0, 16'h0, 0, 0, 0);
        check("R5 masked event", stat, 16'h4000);
        en = '1;
        // R7 R8 write
        pulse(12'h000, 0, 1, 16'hFFFF, 0, 0, 0);
        check("R7/R8 write field only", stat, 16'h6000);
        pulse(12'h000, 0, 1, 16'h9FFF, 0, 0, 0);
        check("R8 write other bits", stat, 16'h0000);
        // R9 window
        pulse(12'h000, 0, 0, 16'h0, 1, 16'sd23230, -16'sd23230);
        check("R9 at limit", stat, 16'h0000);
        pulse(12'h000, 0, 0, 16'h0, 1, 16'sd23231, 0);
        check("R9 x above", stat, 16'h8040);
        pulse(12'h000, 1, 0, 16'h0, 0, 0, 0);
        check("R3 clear xy", stat, 16'h0000);
        pulse(12'h000, 0, 0, 16'h0, 1, 0, -16'sd23231);
        check("R9 y below", stat, 16'h8040);
        pulse(12'h000, 1, 0, 16'h0, 0, 0, 0);
        pulse(12'h000, 0, 0, 16'h0, 0, 16'sd30000, 0);
        check("R9 no valid", stat, 16'h0000);
        // R10 autocal
        acal = 1'b1;
        pulse(12'h008, 0, 0, 16'h0, 0, 0, 0);
        check("R10 crc blocked", stat, 16'h0000);
        acal = 1'b0;
        pulse(12'h008, 0, 0, 16'h0, 0, 0, 0);
        check("R10 crc set", stat, 16'h8008);
        acal = 1'b1;
        tick();
        check("R10 crc forced off", stat, 16'h8000);
        acal = 1'b0;
        pulse(12'h000, 1, 0, 16'h0, 0, 0, 0);
        // R1: second reset with straps low
        strap_hi = 1'b0;
        rst = 1'b1; repeat (2) tick(); rst = 1'b0; tick();
        check("R1 reset value", stat, 16'h8001);
        // R2: random run against the model
        exp_w = stat;
        for (int n = 0; n < 4000; n++) begin
            logic [11:0] re, rm;
            logic rr, rw, rv, ra;
            logic [15:0] rwd;
            logic signed [15:0] rx, ry;
            check("R2 random", stat, exp_w);
            re  = 12'($urandom & $urandom & $urandom);
            rm  = ~12'($urandom & $urandom);
            rr  = ($urandom % 4) == 0;
            rw  = ($urandom % 16) == 0;
            rwd = 16'($urandom);
            rv  = ($urandom % 3) == 0;
            ra  = ($urandom % 10) == 0;
            case ($urandom % 4)
                0: rx = 16'sd23231;
                1: rx = -16'sd23230;
                default: rx = 16'($urandom);
            endcase
            ry = (($urandom % 2) == 0) ? -16'sd23231 : 16'($urandom % 20000);
            en = rm; acal = ra;
            exp_w = model(exp_w, re, rm, rr, rw, rwd, rv, rx, ry, ra);
            pulse(re, rr, rw, rwd, rv, rx, ry);
        end
        check("R2 random final", stat, exp_w);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule